// File: doc/BRIEF.md
# Exception Control Register Bank

This block holds the system-control state that a processor core consults when it takes a trap or an interrupt. There are four registers: a saved exception PC, a cause word, a status word and a faulting-address register. When the core signals an exception, the block does four things in the same clock edge. It records the address of the offending instruction, stores a 4-bit reason code and, when the core flags a memory fault, latches the faulting address. It also pushes a three-level stack of kernel/user and interrupt-enable pairs, so that the handler runs in kernel mode with interrupts off. A return-from-exception strobe pops that stack.

Interrupt levels are tracked in pending bits that sit beside a per-level mask. Hardware lines set their pending bits no matter what the mask or the enable says. Software levels are set and cleared by register writes. The block asserts an interrupt request whenever the current enable is on and at least one pending level is unmasked. Software reads and writes each register through an index-addressed port. Handler fetch and address translation are left to the core.

Top module: `exc_ctl_regs`

## Requirements
- R1: After reset every register reads zero. In particular the mode stack reads 000000, which puts the current pair in kernel mode with interrupts off, and `irq_req` is low.
- R2: `sw_ridx` selects the register: 0 status, 1 cause, 2 exception PC, 3 fault address. The read data is combinational from the registers. Status holds the mask in bits 15:8 and the mode stack in bits 5:0, arranged as old 5:4, previous 3:2 and current 1:0; each pair is {k,e}, where k=1 means user and e=1 means enabled. Cause holds the pending bits in 15:8 and the code in 5:2. All other bits of both words read 0.
- R3: On `exc_valid`, the stack shifts left by two bits and the current pair becomes 00.
- R4: On `rfe` without `exc_valid`, the stack shifts right by two bits and the old pair keeps its value. When both strobes are high in the same cycle, the exception wins.
- R5: On `exc_valid`, the exception PC is loaded with `exc_pc` minus 4.
- R6: On `exc_valid`, cause bits 5:2 take `exc_code`. The codes are 0 external interrupt, 4 load/fetch address error, 5 store address error, 6 fetch bus error, 7 data bus error, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow. Software writes to the cause register never change the code.
- R7: A high hardware line `hw_irq[j]` sets pending level 3+j (cause bit 11+j). It does so regardless of the mask and of the enable bits, and the bit stays set afterwards.
- R8: A software write to the cause register clears a hardware pending bit where the written bit is 0. A written 1 leaves that bit unchanged. A hardware line that is high in the same cycle keeps its bit set.
- R9: Pending levels 0 to 2 (cause bits 10:8) are software levels. A write to the cause register loads them with the written bits.
- R10: `irq_req` is high exactly when the current e bit (status bit 0) is 1 and some pending bit is 1 while the mask bit at the same position is also 1.
- R11: On `exc_valid` with `exc_addr_vld`, the fault-address register loads `exc_badaddr`. Without `exc_addr_vld` it keeps its value.
- R12: Software writes load the status mask and stack, the exception PC and the fault address. In the same cycle, an exception's update of a register takes precedence over a software write to it, and a return-from-exception takes precedence over a software write to the stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 4 | Reason code for the exception |
| exc_pc | input | 32 | PC value at the exception (already advanced by 4) |
| exc_addr_vld | input | 1 | The exception carries a faulting address |
| exc_badaddr | input | 32 | Faulting memory address |
| rfe | input | 1 | Return-from-exception strobe |
| hw_irq | input | 5 | Hardware interrupt lines |
| sw_we | input | 1 | Software write enable |
| sw_widx | input | 2 | Software write register index |
| sw_wdata | input | 32 | Software write data |
| sw_ridx | input | 2 | Software read register index |
| sw_rdata | output | 32 | Software read data |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
Every register update lands on the clock edge that samples the stimulus, and `sw_rdata` and `irq_req` follow combinationally. Each result is therefore due exactly one edge after its inputs are presented. The bench drives inputs at the falling edge and applies the same inputs to its reference model at the next rising edge. It then compares all four registers and the request at the following falling edge, stepping `sw_ridx` in small delays that stay clear of both edges. Pending bits get extra idle cycles before they are read, so that stickiness is checked apart from the cycle that set them.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

   typedef enum logic [1:0] {
      CREG_STATUS  = 2'd0,
      CREG_CAUSE   = 2'd1,
      CREG_EPC     = 2'd2,
      CREG_BADADDR = 2'd3
   } creg_idx_e;

   typedef enum logic [3:0] {
      XC_EXT_INT   = 4'd0,
      XC_ADDR_LD   = 4'd4,
      XC_ADDR_ST   = 4'd5,
      XC_BUS_FETCH = 4'd6,
      XC_BUS_DATA  = 4'd7,
      XC_SYSCALL   = 4'd8,
      XC_BREAK     = 4'd9,
      XC_RSVD_INSN = 4'd10,
      XC_OVERFLOW  = 4'd12
   } xcode_e;

   localparam int unsigned PAIR_W    = 2;
   localparam int unsigned MASK_LSB  = 8;
   localparam int unsigned PEND_LSB  = 8;
   localparam int unsigned CODE_LSB  = 2;

endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
   parameter int unsigned DEPTH  = 3,
   parameter int unsigned LEVELS = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    push,
   input  logic                    pop,
   input  logic                    wr_en,
   input  logic [2*DEPTH-1:0]      wr_stack,
   input  logic [LEVELS-1:0]       wr_mask,
   output logic [2*DEPTH-1:0]      stack_q,
   output logic [LEVELS-1:0]       mask_q
);
   import exc_ctl_pkg::*;

   localparam int unsigned SW = PAIR_W * DEPTH;

   initial begin
      if (DEPTH < 2 || SW > MASK_LSB)
         $fatal(1, "exc_mode_stack: DEPTH must be 2..%0d", MASK_LSB / PAIR_W);
   end

   logic [SW-1:0] stack_d;
   logic [SW-1:0] pushed;
   logic [SW-1:0] popped;

   // push: every pair moves one slot older, fresh pair is kernel/disabled
   assign pushed = {stack_q[SW-PAIR_W-1:0], {PAIR_W{1'b0}}};
   // pop: every pair moves one slot younger, the oldest pair is duplicated
   assign popped = {stack_q[SW-1:SW-PAIR_W], stack_q[SW-1:PAIR_W]};

   always_comb begin
      if (push)
         stack_d = pushed;
      else if (pop)
         stack_d = popped;
      else if (wr_en)
         stack_d = wr_stack;
      else
         stack_d = stack_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stack_q <= '0;
         mask_q  <= '0;
      end else begin
         stack_q <= stack_d;
         if (wr_en)
            mask_q <= wr_mask;
      end
   end

endmodule

// File: rtl/exc_pending.sv
module exc_pending #(
   parameter int unsigned N_SW = 3,
   parameter int unsigned N_HW = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [N_SW+N_HW-1:0]   wr_val,
   input  logic [N_HW-1:0]        hw_irq,
   output logic [N_SW+N_HW-1:0]   pend_q
);
   localparam int unsigned LEVELS = N_SW + N_HW;

   initial begin
      if (N_HW == 0)
         $fatal(1, "exc_pending: at least one hardware level is required");
   end

   for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
      if (lv < N_SW) begin : g_soft
         // software level: plain writable bit
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_q[lv] <= 1'b0;
            else if (wr_en)
               pend_q[lv] <= wr_val[lv];
         end
      end else begin : g_hard
         // hardware level: sticky set, write-zero-to-clear, set wins
         logic keep;
         assign keep = wr_en ? (pend_q[lv] & wr_val[lv]) : pend_q[lv];
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_q[lv] <= 1'b0;
            else
               pend_q[lv] <= keep | hw_irq[lv - N_SW];
         end
      end
   end

endmodule

// File: rtl/exc_irq_eval.sv
module exc_irq_eval #(
   parameter int unsigned LEVELS = 8
) (
   input  logic [LEVELS-1:0] pend,
   input  logic [LEVELS-1:0] mask,
   input  logic              cur_en,
   output logic              irq
);
   logic [LEVELS-1:0] live;

   assign live = pend & mask;
   assign irq  = cur_en & (|live);

endmodule

// File: rtl/exc_ctl_regs.sv
module exc_ctl_regs #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned N_HW    = 5,
   parameter int unsigned N_SW    = 3,
   parameter int unsigned DEPTH   = 3,
   parameter int unsigned CODE_W  = 4,
   parameter int unsigned PC_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exc_valid,
   input  logic [CODE_W-1:0] exc_code,
   input  logic [XLEN-1:0]   exc_pc,
   input  logic              exc_addr_vld,
   input  logic [XLEN-1:0]   exc_badaddr,
   input  logic              rfe,
   input  logic [N_HW-1:0]   hw_irq,
   input  logic              sw_we,
   input  logic [1:0]        sw_widx,
   input  logic [XLEN-1:0]   sw_wdata,
   input  logic [1:0]        sw_ridx,
   output logic [XLEN-1:0]   sw_rdata,
   output logic              irq_req
);
   import exc_ctl_pkg::*;

   localparam int unsigned LEVELS  = N_SW + N_HW;
   localparam int unsigned STACK_W = PAIR_W * DEPTH;

   initial begin
      if (XLEN < MASK_LSB + LEVELS)
         $fatal(1, "exc_ctl_regs: XLEN too small for %0d levels", LEVELS);
      if (CODE_LSB + CODE_W > PEND_LSB)
         $fatal(1, "exc_ctl_regs: code field overlaps pending field");
   end

   // write decode
   logic wr_status, wr_cause, wr_epc, wr_bad;
   always_comb begin
      wr_status = 1'b0;
      wr_cause  = 1'b0;
      wr_epc    = 1'b0;
      wr_bad    = 1'b0;
      if (sw_we) begin
         unique case (creg_idx_e'(sw_widx))
            CREG_STATUS:  wr_status = 1'b1;
            CREG_CAUSE:   wr_cause  = 1'b1;
            CREG_EPC:     wr_epc    = 1'b1;
            CREG_BADADDR: wr_bad    = 1'b1;
            default: ;
         endcase
      end
   end

   // status: mode stack and mask
   logic [STACK_W-1:0] stack_q;
   logic [LEVELS-1:0]  mask_q;

   exc_mode_stack #(
      .DEPTH  (DEPTH),
      .LEVELS (LEVELS)
   ) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (exc_valid),
      .pop      (rfe),
      .wr_en    (wr_status),
      .wr_stack (sw_wdata[STACK_W-1:0]),
      .wr_mask  (sw_wdata[MASK_LSB +: LEVELS]),
      .stack_q  (stack_q),
      .mask_q   (mask_q)
   );

   // cause: pending levels
   logic [LEVELS-1:0] pend_q;

   exc_pending #(
      .N_SW (N_SW),
      .N_HW (N_HW)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_cause),
      .wr_val (sw_wdata[PEND_LSB +: LEVELS]),
      .hw_irq (hw_irq),
      .pend_q (pend_q)
   );

   // cause: exception code, exception PC, fault address
   logic [CODE_W-1:0] code_q;
   logic [XLEN-1:0]   epc_q;
   logic [XLEN-1:0]   bad_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= '0;
         epc_q  <= '0;
         bad_q  <= '0;
      end else begin
         if (exc_valid)
            code_q <= exc_code;

         if (exc_valid)
            epc_q <= exc_pc - XLEN'(PC_STEP);
         else if (wr_epc)
            epc_q <= sw_wdata;

         if (exc_valid && exc_addr_vld)
            bad_q <= exc_badaddr;
         else if (wr_bad)
            bad_q <= sw_wdata;
      end
   end

   // interrupt request
   exc_irq_eval #(
      .LEVELS (LEVELS)
   ) u_irq (
      .pend   (pend_q),
      .mask   (mask_q),
      .cur_en (stack_q[0]),
      .irq    (irq_req)
   );

   // read mux
   logic [XLEN-1:0] status_word;
   logic [XLEN-1:0] cause_word;

   always_comb begin
      status_word = '0;
      status_word[STACK_W-1:0]      = stack_q;
      status_word[MASK_LSB +: LEVELS] = mask_q;
      cause_word  = '0;
      cause_word[PEND_LSB +: LEVELS]  = pend_q;
      cause_word[CODE_LSB +: CODE_W]  = code_q;
   end

   always_comb begin
      unique case (creg_idx_e'(sw_ridx))
         CREG_STATUS:  sw_rdata = status_word;
         CREG_CAUSE:   sw_rdata = cause_word;
         CREG_EPC:     sw_rdata = epc_q;
         CREG_BADADDR: sw_rdata = bad_q;
         default:      sw_rdata = '0;
      endcase
   end

endmodule

// File: rtl/exc_ctl_chk.sv
module exc_ctl_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned N_HW    = 5,
   parameter int unsigned N_SW    = 3,
   parameter int unsigned DEPTH   = 3,
   parameter int unsigned CODE_W  = 4,
   parameter int unsigned PC_STEP = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   exc_valid,
   input logic [CODE_W-1:0]      exc_code,
   input logic [XLEN-1:0]        exc_pc,
   input logic                   rfe,
   input logic [N_HW-1:0]        hw_irq,
   input logic [2*DEPTH-1:0]     stack_q,
   input logic [N_SW+N_HW-1:0]   pend_q,
   input logic [CODE_W-1:0]      code_q,
   input logic [XLEN-1:0]        epc_q,
   input logic                   irq_req
);
   localparam int unsigned SW = 2 * DEPTH;

   a_r3_push_kernel: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> stack_q == {$past(stack_q[SW-3:0]), 2'b00});

   a_r4_pop_restore: assert property (@(posedge clk) disable iff (!rst_n)
      (rfe && !exc_valid) |=> stack_q == {$past(stack_q[SW-1:SW-2]), $past(stack_q[SW-1:2])});

   a_r5_epc_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> epc_q == $past(exc_pc) - XLEN'(PC_STEP));

   a_r6_code_load: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> code_q == $past(exc_code));

   a_r7_hw_sets_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_irq) |=> ((pend_q[N_SW+N_HW-1:N_SW] & $past(hw_irq)) == $past(hw_irq)));

   a_r10_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> stack_q[0]);

   a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_q != '0));

endmodule

bind exc_ctl_regs exc_ctl_chk #(
   .XLEN    (XLEN),
   .N_HW    (N_HW),
   .N_SW    (N_SW),
   .DEPTH   (DEPTH),
   .CODE_W  (CODE_W),
   .PC_STEP (PC_STEP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .exc_valid (exc_valid),
   .exc_code  (exc_code),
   .exc_pc    (exc_pc),
   .rfe       (rfe),
   .hw_irq    (hw_irq),
   .stack_q   (stack_q),
   .pend_q    (pend_q),
   .code_q    (code_q),
   .epc_q     (epc_q),
   .irq_req   (irq_req)
);

// File: tb/sim_exc_ctl_regs.sv
module sim_exc_ctl_regs;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        exc_valid;
   logic [3:0]  exc_code;
   logic [31:0] exc_pc;
   logic        exc_addr_vld;
   logic [31:0] exc_badaddr;
   logic        rfe;
   logic [4:0]  hw_irq;
   logic        sw_we;
   logic [1:0]  sw_widx;
   logic [31:0] sw_wdata;
   logic [1:0]  sw_ridx;
   logic [31:0] sw_rdata;
   logic        irq_req;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;  // 50 MHz

   exc_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
      .exc_pc(exc_pc), .exc_addr_vld(exc_addr_vld), .exc_badaddr(exc_badaddr),
      .rfe(rfe), .hw_irq(hw_irq), .sw_we(sw_we), .sw_widx(sw_widx),
      .sw_wdata(sw_wdata), .sw_ridx(sw_ridx), .sw_rdata(sw_rdata),
      .irq_req(irq_req)
   );

   // reference state
   logic [5:0]  m_stack;
   logic [7:0]  m_mask;
   logic [7:0]  m_pend;
   logic [3:0]  m_code;
   logic [31:0] m_epc;
   logic [31:0] m_bad;

   function automatic logic [31:0] status_of(logic [5:0] s, logic [7:0] m);
      return {16'h0, m, 2'b00, s};
   endfunction

   function automatic logic [31:0] cause_of(logic [7:0] p, logic [3:0] c);
      return {16'h0, p, 2'b00, c, 2'b00};
   endfunction

   function automatic logic irq_of(logic [5:0] s, logic [7:0] m, logic [7:0] p);
      return s[0] && ((m & p) != 8'h0);
   endfunction

   task automatic model_edge();
      logic wst, wca, wep, wba;
      logic [7:0] base;
      wst = sw_we && sw_widx == 2'd0;
      wca = sw_we && sw_widx == 2'd1;
      wep = sw_we && sw_widx == 2'd2;
      wba = sw_we && sw_widx == 2'd3;
      if (exc_valid)     m_stack = {m_stack[3:0], 2'b00};
      else if (rfe)      m_stack = {m_stack[5:4], m_stack[5:2]};
      else if (wst)      m_stack = sw_wdata[5:0];
      if (wst)           m_mask  = sw_wdata[15:8];
      base = m_pend;
      if (wca) begin
         base[2:0] = sw_wdata[10:8];
         base[7:3] = m_pend[7:3] & sw_wdata[15:11];
      end
      m_pend = base | {hw_irq, 3'b000};
      if (exc_valid)     m_code = exc_code;
      if (exc_valid)     m_epc  = exc_pc - 32'd4;
      else if (wep)      m_epc  = sw_wdata;
      if (exc_valid && exc_addr_vld) m_bad = exc_badaddr;
      else if (wba)      m_bad  = sw_wdata;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      exc_valid = 0; exc_code = 0; exc_pc = 0; exc_addr_vld = 0;
      exc_badaddr = 0; rfe = 0; hw_irq = 0; sw_we = 0; sw_widx = 0; sw_wdata = 0;
   endtask

   // called at a falling edge; reads every register through the port
   task automatic compare_all(string ctx);
      sw_ridx = 2'd0; #1;
      chk({ctx, " R2 R3 R4 R12 status"}, sw_rdata, status_of(m_stack, m_mask));
      sw_ridx = 2'd1; #1;
      chk({ctx, " R2 R6 R7 R8 R9 cause"}, sw_rdata, cause_of(m_pend, m_code));
      sw_ridx = 2'd2; #1;
      chk({ctx, " R5 R12 epc"}, sw_rdata, m_epc);
      sw_ridx = 2'd3; #1;
      chk({ctx, " R11 R12 badaddr"}, sw_rdata, m_bad);
      chk({ctx, " R10 irq"}, {31'h0, irq_req}, {31'h0, irq_of(m_stack, m_mask, m_pend)});
   endtask

   // inputs already set at a falling edge: apply one edge, then check
   task automatic step(string ctx);
      @(posedge clk);
      model_edge();
      @(negedge clk);
      idle_inputs();
      compare_all(ctx);
   endtask

   task automatic wr(logic [1:0] idx, logic [31:0] d, string ctx);
      sw_we = 1; sw_widx = idx; sw_wdata = d;
      step(ctx);
   endtask

   function automatic logic [3:0] pick_code(int unsigned r);
      case (r % 9)
         0: return 4'd0;  1: return 4'd4;  2: return 4'd5;
         3: return 4'd6;  4: return 4'd7;  5: return 4'd8;
         6: return 4'd9;  7: return 4'd10; default: return 4'd12;
      endcase
   endfunction

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd24681));
      idle_inputs();
      sw_ridx = 0;
      rst_n = 0;
      m_stack = 0; m_mask = 0; m_pend = 0; m_code = 0; m_epc = 0; m_bad = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      compare_all("R1 reset");

      // R12 software writes, then R3 push with address (R5 R6 R11)
      wr(2'd0, 32'h0000_A5_07, "R12 status write");
      wr(2'd2, 32'h1234_5678, "R12 epc write");
      exc_valid = 1; exc_code = 4'd4; exc_pc = 32'h0000_1004;
      exc_addr_vld = 1; exc_badaddr = 32'hDEAD_BEEF;
      step("R3 R5 R6 R11 exception");
      // exception without address keeps fault address
      exc_valid = 1; exc_code = 4'd12; exc_pc = 32'h0000_2000;
      step("R11 keep badaddr");
      // R4 pops twice, old pair retained
      rfe = 1; step("R4 pop 1");
      rfe = 1; step("R4 pop 2");
      // R4 exception beats rfe
      exc_valid = 1; rfe = 1; exc_code = 4'd8; exc_pc = 32'h40;
      step("R4 exc over rfe");
      // R12 exception beats epc/status writes
      exc_valid = 1; exc_code = 4'd9; exc_pc = 32'h80;
      sw_we = 1; sw_widx = 2'd2; sw_wdata = 32'hFFFF_0000;
      step("R12 exc over epc write");
      // R6 code not writable by software
      wr(2'd1, 32'h0000_003C, "R6 cause write keeps code");

      // R7 pending while masked and disabled
      wr(2'd0, 32'h0000_0000, "R10 mask off");
      hw_irq = 5'b00101; step("R7 hw set masked");
      step("R7 sticky idle");
      step("R7 sticky idle 2");
      // R10 enable and unmask
      wr(2'd0, 32'h0000_0800 | 32'h1, "R10 unmasked enabled");
      wr(2'd0, 32'h0000_0800, "R10 enable off");
      wr(2'd0, 32'h0000_1001, "R10 mask other level");
      // R8 write one keeps, write zero clears, hw set wins
      wr(2'd1, 32'h0000_FF00, "R8 write ones keep");
      sw_we = 1; sw_widx = 2'd1; sw_wdata = 32'h0; hw_irq = 5'b00100;
      step("R8 hw set beats clear");
      wr(2'd1, 32'h0000_0000, "R8 clear all");
      // R9 software levels
      wr(2'd1, 32'h0000_0500, "R9 sw levels set");
      wr(2'd0, 32'h0000_0401, "R9 R10 sw level irq");
      wr(2'd1, 32'h0000_0000, "R9 sw levels clear");

      // random mix
      for (int i = 0; i < 600; i++) begin
         exc_valid    = ($urandom % 8) == 0;
         exc_code     = pick_code($urandom);
         exc_pc       = $urandom;
         exc_addr_vld = $urandom % 2;
         exc_badaddr  = $urandom;
         rfe          = ($urandom % 6) == 0;
         hw_irq       = 5'($urandom & $urandom & $urandom);
         sw_we        = ($urandom % 3) == 0;
         sw_widx      = 2'($urandom);
         sw_wdata     = $urandom;
         step("R3 R4 R7 R8 R10 random");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule